// File: doc/BRIEF.md
# Predicated Compare-and-Shift Datapath Core

This block is a small single-issue processing core. Every instruction is guarded by a condition code that is tested against three relation flags (greater, equal, less). Those flags are left behind by the most recent compare. When the guard fails, the instruction retires as a no-op: no register is written, no flag changes and no branch is taken. Arithmetic instructions can shift their second register operand left by an immediate count within the same instruction. This removes the separate shift step from address or scale arithmetic. A guarded branch moves a small program counter. With it, loops such as a subtraction-based greatest common divisor need no extra branch to pick between their two arms.

The program lives in a small internal instruction store. It is written word by word through a write port while the core is stalled. The core then restarts from address zero after reset and runs one instruction per clock while `runEn` is high. It stops for good on a halt instruction and raises `done`. A read port exposes any register so that results can be observed.

Instruction word layout: [31:28] opcode, [27:25] condition, [24:22] destination, [21:19] first source, [18:16] second source, [15:11] shift count, [15:0] immediate (also the branch target).

Top module: `cond_exec_core`

## Requirements
- R1: After reset, `pc` is 0, `done` is 0, every register reads 0 and `flags` is 3'b010. The flag bits are {greater, equal, less}.
- R2: Compare (opcode 3) sets exactly one flag from an unsigned comparison of the first source against the shifted second source. It writes no register.
- R3: No instruction other than compare changes `flags`.
- R4: An instruction whose condition is false writes no register, leaves the flags unchanged and advances `pc` by one.
- R5: The condition field encodes 0 = always, 1 = equal set, 2 = equal clear, 3 = greater set and 4 = less set. Codes 5 to 7 are never true.
- R6: Add (opcode 1) and subtract (opcode 2) write rd = rs1 ± (rs2 << shift), taken modulo 2^32.
- R7: Move (opcode 0) writes rd = rs2 << shift. Load-immediate (opcode 4) writes the zero-extended 16-bit immediate.
- R8: Branch (opcode 5) loads `pc` with the target when its condition holds. Otherwise it advances `pc` by one.
- R9: Halt (opcode 15) is unconditional. It sets `done` on the edge that executes it, and from then on `pc` and all state hold. A program of N executed instructions, ending with the halt, raises `done` after exactly N rising edges.
- R10: The four-instruction loop of compare, subtract-if-greater, subtract-if-less and branch-if-not-equal leaves the GCD of two positive values in both operand registers.
- R11: While `runEn` is low the core holds `pc`, registers and flags. Program words written through the write port land at the given address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of pc, flags, registers and done |
| runEn | input | 1 | Execute one instruction per cycle while high |
| progWe | input | 1 | Instruction store write strobe |
| progAddr | input | PCW | Instruction store write address |
| progData | input | 32 | Instruction word to store |
| regSel | input | 3 | Register index for the read port |
| regData | output | DW | Contents of the selected register |
| flags | output | 3 | {greater, equal, less} |
| pc | output | PCW | Current program counter |
| done | output | 1 | Halt reached |

## Verification
Every instruction completes in one cycle. Its register write, flag update and program-counter change all land on the single rising edge that executes it, and `done` rises on the edge that executes the halt. The bench drives inputs on falling edges and reads outputs at the following falling edge. It counts rising edges from the moment `runEn` goes high and compares that count with the number of instructions the program must execute. Register results are read through the combinational read port only after `done`, or during a deliberate stall, when no edge can change them.

// File: rtl/cx_pkg.sv
package cx_pkg;

  localparam int IW = 32;

  typedef enum logic [3:0] {
    OP_MOV  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_CMP  = 4'd3,
    OP_LDI  = 4'd4,
    OP_BR   = 4'd5,
    OP_HALT = 4'd15
  } opcode_e;

  typedef enum logic [2:0] {
    C_AL = 3'd0,
    C_EQ = 3'd1,
    C_NE = 3'd2,
    C_GT = 3'd3,
    C_LT = 3'd4
  } cond_e;

  typedef enum logic [1:0] {
    SEL_PASS = 2'd0,
    SEL_ADD  = 2'd1,
    SEL_SUB  = 2'd2,
    SEL_IMM  = 2'd3
  } resSel_e;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } flags_t;

  typedef struct packed {
    logic        regWe;
    logic        flagWe;
    resSel_e     resSel;
    logic [2:0]  rd;
    logic [2:0]  rn;
    logic [2:0]  rm;
    logic [4:0]  shamt;
    logic [15:0] imm;
  } strobe_t;

endpackage

// File: rtl/cx_irom.sv
module cx_irom #(
  parameter int PCW = 5,
  parameter int IW  = 32
) (
  input  logic           clk,
  input  logic           we,
  input  logic [PCW-1:0] waddr,
  input  logic [IW-1:0]  wdata,
  input  logic [PCW-1:0] raddr,
  output logic [IW-1:0]  rdata
);
  localparam int DEPTH = 1 << PCW;

  logic [IW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/cx_shift.sv
module cx_shift #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]         din,
  input  logic [$clog2(DW)-1:0] amt,
  output logic [DW-1:0]         dout
);
  localparam int SHW = $clog2(DW);

  logic [DW-1:0] stage [SHW+1];

  assign stage[0] = din;

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    assign stage[s+1] = amt[s] ? (stage[s] << (1 << s)) : stage[s];
  end

  assign dout = stage[SHW];
endmodule

// File: rtl/cx_ctrl.sv
module cx_ctrl
  import cx_pkg::*;
#(
  parameter int PCW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           runEn,
  input  logic [IW-1:0]  instr,
  input  flags_t         flagsIn,
  output strobe_t        strb,
  output logic [PCW-1:0] pcOut,
  output logic           doneOut
);
  logic [PCW-1:0] pcQ;
  logic           doneQ;
  logic [3:0]     op;
  logic [2:0]     cond;
  logic           condOk;
  logic           active;
  logic           isWrite;
  logic           takeBr;
  logic           isHalt;

  assign op     = instr[31:28];
  assign cond   = instr[27:25];
  assign active = runEn && !doneQ;

  always_comb begin
    case (cond)
      C_AL:    condOk = 1'b1;
      C_EQ:    condOk = flagsIn.eq;
      C_NE:    condOk = !flagsIn.eq;
      C_GT:    condOk = flagsIn.gt;
      C_LT:    condOk = flagsIn.lt;
      default: condOk = 1'b0;
    endcase
  end

  always_comb begin
    isWrite = 1'b0;
    strb.resSel = SEL_PASS;
    case (op)
      OP_MOV: begin isWrite = 1'b1; strb.resSel = SEL_PASS; end
      OP_ADD: begin isWrite = 1'b1; strb.resSel = SEL_ADD;  end
      OP_SUB: begin isWrite = 1'b1; strb.resSel = SEL_SUB;  end
      OP_LDI: begin isWrite = 1'b1; strb.resSel = SEL_IMM;  end
      default: ;
    endcase
  end

  assign strb.regWe  = active && condOk && isWrite;
  assign strb.flagWe = active && condOk && (op == OP_CMP);
  assign strb.rd     = instr[24:22];
  assign strb.rn     = instr[21:19];
  assign strb.rm     = instr[18:16];
  assign strb.shamt  = instr[15:11];
  assign strb.imm    = instr[15:0];

  assign takeBr = active && condOk && (op == OP_BR);
  assign isHalt = active && (op == OP_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcQ   <= '0;
      doneQ <= 1'b0;
    end else if (active) begin
      if (isHalt) begin
        doneQ <= 1'b1;
      end else if (takeBr) begin
        pcQ <= instr[PCW-1:0];
      end else begin
        pcQ <= pcQ + 1'b1;
      end
    end
  end

  assign pcOut   = pcQ;
  assign doneOut = doneQ;
endmodule

// File: rtl/cx_dpath.sv
module cx_dpath
  import cx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobe_t       strb,
  input  logic [2:0]    dbgSel,
  output logic [DW-1:0] dbgData,
  output flags_t        flagsOut
);
  localparam int RW  = $clog2(NREG);
  localparam int SHW = $clog2(DW);

  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] opA;
  logic [DW-1:0] opRaw;
  logic [DW-1:0] opB;
  logic [DW-1:0] result;
  flags_t        flagsQ;
  flags_t        relNext;

  assign opA   = rf[strb.rn[RW-1:0]];
  assign opRaw = rf[strb.rm[RW-1:0]];

  cx_shift #(.DW(DW)) u_shift (
    .din  (opRaw),
    .amt  (strb.shamt[SHW-1:0]),
    .dout (opB)
  );

  always_comb begin
    case (strb.resSel)
      SEL_PASS: result = opB;
      SEL_ADD:  result = opA + opB;
      SEL_SUB:  result = opA - opB;
      default:  result = {{(DW-16){1'b0}}, strb.imm};
    endcase
  end

  assign relNext.gt = (opA > opB);
  assign relNext.eq = (opA == opB);
  assign relNext.lt = (opA < opB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (strb.regWe) begin
      rf[strb.rd[RW-1:0]] <= result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagsQ <= '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
    end else if (strb.flagWe) begin
      flagsQ <= relNext;
    end
  end

  assign dbgData  = rf[dbgSel[RW-1:0]];
  assign flagsOut = flagsQ;
endmodule

// File: rtl/cond_exec_core.sv
module cond_exec_core
  import cx_pkg::*;
#(
  parameter int DW  = 32,
  parameter int PCW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           runEn,
  input  logic           progWe,
  input  logic [PCW-1:0] progAddr,
  input  logic [31:0]    progData,
  input  logic [2:0]     regSel,
  output logic [DW-1:0]  regData,
  output logic [2:0]     flags,
  output logic [PCW-1:0] pc,
  output logic           done
);
  localparam int NREG = 8;

  logic [IW-1:0] instrWord;
  strobe_t       strb;
  flags_t        flagsNow;

  cx_irom #(.PCW(PCW), .IW(IW)) u_irom (
    .clk   (clk),
    .we    (progWe),
    .waddr (progAddr),
    .wdata (progData),
    .raddr (pc),
    .rdata (instrWord)
  );

  cx_ctrl #(.PCW(PCW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .runEn   (runEn),
    .instr   (instrWord),
    .flagsIn (flagsNow),
    .strb    (strb),
    .pcOut   (pc),
    .doneOut (done)
  );

  cx_dpath #(.DW(DW), .NREG(NREG)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .dbgSel   (regSel),
    .dbgData  (regData),
    .flagsOut (flagsNow)
  );

  assign flags = flagsNow;
endmodule

// File: rtl/cx_chk.sv
module cx_chk #(
  parameter int PCW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           runEn,
  input logic           done,
  input logic [PCW-1:0] pc,
  input logic [2:0]     flags,
  input logic [3:0]     opNow
);
  // R2
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags) == 1);

  // R3
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opNow != 4'd3) |=> $stable(flags));

  // R9
  halt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (runEn && !done && opNow == 4'd15) |=> done);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(pc)));

  // R11
  stall_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !runEn |=> ($stable(pc) && $stable(flags)));
endmodule

bind cond_exec_core cx_chk #(.PCW(PCW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .runEn (runEn),
  .done  (done),
  .pc    (pc),
  .flags (flags),
  .opNow (instrWord[31:28])
);

// File: tb/sim_cond_exec_core.sv
module sim_cond_exec_core;
  localparam int CLK_PERIOD = 10;
  localparam int PCW = 5;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           runEn = 1'b0;
  logic           progWe = 1'b0;
  logic [PCW-1:0] progAddr = '0;
  logic [31:0]    progData = '0;
  logic [2:0]     regSel = '0;
  logic [DW-1:0]  regData;
  logic [2:0]     flags;
  logic [PCW-1:0] pc;
  logic           done;

  int checks = 0;
  int errors = 0;

  cond_exec_core #(.DW(DW), .PCW(PCW)) u0 (
    .clk(clk), .rst_n(rst_n), .runEn(runEn), .progWe(progWe),
    .progAddr(progAddr), .progData(progData), .regSel(regSel),
    .regData(regData), .flags(flags), .pc(pc), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] encR(int op, int cond, int rd, int rn, int rm, int sh);
    return {op[3:0], cond[2:0], rd[2:0], rn[2:0], rm[2:0], sh[4:0], 11'b0};
  endfunction

  function automatic logic [31:0] encI(int cond, int rd, int imm);
    return {4'd4, cond[2:0], rd[2:0], 6'b0, imm[15:0]};
  endfunction

  function automatic logic [31:0] encB(int cond, int tgt);
    return {4'd5, cond[2:0], 9'b0, tgt[15:0]};
  endfunction

  function automatic logic [31:0] encH();
    return {4'hF, 28'b0};
  endfunction

  function automatic int refGcd(int a, int b);
    int x = a;
    int y = b;
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    progWe = 1'b1;
    progAddr = a[PCW-1:0];
    progData = d;
    @(negedge clk);
    progWe = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    runEn = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd(int i, output logic [31:0] v);
    regSel = i[2:0];
    #1;
    v = regData;
  endtask

  task automatic runProg(output int cyc);
    cyc = 0;
    runEn = 1'b1;
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) break;
      if (cyc > 5000) begin
        errors++;
        $display("FAIL R9 run limit act %0d exp done", cyc);
        break;
      end
    end
    runEn = 1'b0;
  endtask

  task automatic gcdCase(int a, int b);
    int cyc;
    logic [31:0] v;
    wr(0, encI(0, 0, a));
    wr(1, encI(0, 1, b));
    wr(2, encR(3, 0, 0, 0, 1, 0));
    wr(3, encR(2, 3, 0, 0, 1, 0));
    wr(4, encR(2, 4, 1, 1, 0, 0));
    wr(5, encB(2, 2));
    wr(6, encH());
    doReset();
    runProg(cyc);
    rd(0, v); chk("R10 gcd r0", v, refGcd(a, b));
    rd(1, v); chk("R10 gcd r1", v, refGcd(a, b));
    chk("R10 gcd flags", {29'b0, flags}, 32'h2);
    chk("R9 gcd pc", {27'b0, pc}, 32'd6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog act hung exp finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    logic [31:0] v;
    void'($urandom(32'd4711));

    // Program A: move, add and subtract with shifts (R6, R7), plus a stall (R11)
    wr(0, encI(0, 1, 5));
    wr(1, encI(0, 2, 3));
    wr(2, encR(1, 0, 3, 1, 2, 2));
    wr(3, encR(2, 0, 4, 1, 2, 0));
    wr(4, encR(2, 0, 5, 2, 1, 0));
    wr(5, encR(0, 0, 6, 0, 1, 31));
    wr(6, encI(0, 7, 16'hFFFF));
    wr(7, encR(1, 0, 7, 7, 7, 16));
    wr(8, encH());
    doReset();
    // R1 reset state
    chk("R1 pc", {27'b0, pc}, 0);
    chk("R1 done", {31'b0, done}, 0);
    chk("R1 flags", {29'b0, flags}, 32'h2);
    rd(3, v); chk("R1 reg", v, 0);
    // R11 idle with runEn low
    repeat (4) @(negedge clk);
    chk("R11 idle pc", {27'b0, pc}, 0);
    runEn = 1'b1;
    repeat (3) @(negedge clk);
    runEn = 1'b0;
    chk("R11 pc at stall", {27'b0, pc}, 3);
    repeat (3) @(negedge clk);
    chk("R11 pc held", {27'b0, pc}, 3);
    rd(4, v); chk("R11 reg held", v, 0);
    rd(3, v); chk("R6 add shift2", v, 32'd17);
    runProg(cyc);
    chk("R9 cycles after stall", cyc, 6);
    rd(4, v); chk("R6 sub", v, 32'd2);
    rd(5, v); chk("R6 sub wrap", v, 32'hFFFF_FFFE);
    rd(6, v); chk("R7 mov shift31", v, 32'h8000_0000);
    rd(7, v); chk("R6 add shift16", v, 32'hFFFF_FFFF);
    chk("R3 flags untouched", {29'b0, flags}, 32'h2);
    chk("R9 done", {31'b0, done}, 1);
    repeat (3) @(negedge clk);
    chk("R9 pc holds", {27'b0, pc}, 8);

    // Program B: compare then predicated loads (R2, R4, R5)
    wr(0, encI(0, 1, 10));
    wr(1, encI(0, 2, 20));
    wr(2, encR(3, 0, 0, 1, 2, 0));
    wr(3, encI(3, 3, 7));
    wr(4, encI(4, 4, 8));
    wr(5, encI(1, 5, 9));
    wr(6, encI(2, 6, 1));
    wr(7, encI(5, 7, 1));
    wr(8, encH());
    doReset();
    runProg(cyc);
    chk("R9 cycle count", cyc, 9);
    chk("R2 flags lt", {29'b0, flags}, 32'h1);
    rd(0, v); chk("R2 cmp no write", v, 0);
    rd(1, v); chk("R2 src kept", v, 10);
    rd(3, v); chk("R4 gt false skip", v, 0);
    rd(4, v); chk("R5 lt true", v, 8);
    rd(5, v); chk("R4 eq false skip", v, 0);
    rd(6, v); chk("R5 ne true", v, 1);
    rd(7, v); chk("R5 code5 never", v, 0);

    // Program C: unsigned compare (R2) and a predicated compare that fails (R4)
    wr(0, encI(0, 1, 1));
    wr(1, encI(0, 2, 16'hFFFF));
    wr(2, encR(1, 0, 2, 2, 2, 16));
    wr(3, encR(3, 0, 0, 2, 1, 0));
    wr(4, encR(3, 4, 0, 1, 2, 0));
    wr(5, encH());
    doReset();
    runProg(cyc);
    chk("R2 unsigned gt", {29'b0, flags}, 32'h4);
    chk("R4 false cmp pc", {27'b0, pc}, 5);

    // Program D: branches (R8)
    wr(0, encI(0, 1, 1));
    wr(1, encR(3, 0, 0, 1, 1, 0));
    wr(2, encB(2, 6));
    wr(3, encI(0, 2, 5));
    wr(4, encB(0, 6));
    wr(5, encI(0, 3, 9));
    wr(6, encH());
    doReset();
    runProg(cyc);
    chk("R8 cycles", cyc, 6);
    rd(2, v); chk("R8 not taken falls through", v, 5);
    rd(3, v); chk("R8 taken skips", v, 0);
    chk("R8 pc at target", {27'b0, pc}, 6);

    // R10 directed and random GCD
    gcdCase(12, 18);
    gcdCase(7, 7);
    gcdCase(1, 97);
    gcdCase(270, 192);
    for (int k = 0; k < 8; k++) begin
      gcdCase($urandom_range(300, 1), $urandom_range(300, 1));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule